// File: doc/BRIEF.md
# Audio Sample FIFO with Threshold Service Request

This block is the sample buffer of one audio channel. It holds up to eight 32-bit samples in first-in, first-out order. In transmit use, software pushes samples and the serializer pops them. In receive use, the serializer pushes samples and software pops them. The oldest stored sample is always present on the read-data output, so a pop takes effect on the clock edge where it is sampled.

The block does not publish an exact occupancy. It publishes a 3-bit coarse level in quarter steps. A single service-request output compares that level with a programmable 3-bit threshold:
- When transmitting, it asks for more data while the FIFO is below the threshold.
- When receiving, it asks for a read once the FIFO has filled past the threshold.

The request is combinational and follows the level on every cycle. An interrupt output passes the request through only when the interrupt enable is set. A push into a full FIFO and a pop from an empty FIFO are dropped and flagged. A synchronous flush empties the buffer, and direction changes are meant to be made while flushed.

Top module: `audio_fifo_req`

## Requirements
- R1: Accepted pushes are popped in the same order. `rd_data` always shows the oldest stored sample.
- R2: `level` encodes the stored count n (depth 8) as follows: n=0 gives 000, n=1 gives 001, n=2..3 gives 010, n=4..5 gives 011, n=6..7 gives 100, and n=8 gives 101.
- R3: With `rx_mode`=0, `req` is 1 exactly when `level` ≤ T, where T is the effective threshold code. Codes 000 to 100 mean empty, quarter, half, three quarters and full.
- R4: With `rx_mode`=1, `req` is 1 exactly when `level` > T. With T=000 this means at least one sample is stored.
- R5: Threshold codes 101, 110 and 111 act as 100 (full).
- R6: `irq` is 1 exactly when `req` is 1 and `irq_en` is 1.
- R7: A push while 8 samples are stored is dropped and leaves the stored contents intact. `overrun` is high in that cycle. This holds even if a pop is sampled in the same cycle, and that pop still proceeds.
- R8: A pop while empty is dropped and `underrun` is high in that cycle. A push in the same cycle is still stored.
- R9: `flush` empties the FIFO on the next edge and overrides a push or pop in the same cycle. While `flush` is high, neither `overrun` nor `underrun` is raised.
- R10: After reset `level` is 000, and `overrun` and `underrun` are low while no push or pop is applied.
- R11: A push and a pop in the same cycle, with the FIFO neither empty nor full, leave the count unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous empty |
| rx_mode | input | 1 | 0 = transmit, 1 = receive |
| thresh | input | 3 | Request threshold code |
| irq_en | input | 1 | Interrupt enable |
| push | input | 1 | Write a sample |
| wr_data | input | 32 | Sample to write |
| pop | input | 1 | Remove the oldest sample |
| rd_data | output | 32 | Oldest stored sample |
| level | output | 3 | Quarter-step fill code |
| req | output | 1 | Service request |
| irq | output | 1 | Gated request |
| overrun | output | 1 | Push dropped because full |
| underrun | output | 1 | Pop dropped because empty |

## Verification
The bench fills the FIFO one sample at a time, from empty to full. At each count it sweeps both directions, all eight threshold codes and both enable values. This catches any off-by-one at a quarter boundary, a request sense that is inverted in one direction, and a reserved threshold that is decoded as something other than full.

The bench also attacks the following corner cases:
- A push into a full FIFO together with a pop. A design that admits this push would corrupt the oldest or the newest entry.
- A pop from an empty FIFO together with a push. A design that drops this push would lose a sample.
- A flush that arrives with a push. A design that stores this push would report a non-zero level after the flush.
- Simultaneous push and pop in mid-fill. A design that mishandles the pointers would reorder the drained data.

// File: rtl/audio_fifo_req.sv
module audio_fifo_req #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              rx_mode,
  input  logic [2:0]        thresh,
  input  logic              irq_en,
  input  logic              push,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        level,
  output logic              req,
  output logic              irq,
  output logic              overrun,
  output logic              underrun
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int Q  = DEPTH / 4;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic              full, empty, wr_ok, rd_ok;
  logic [2:0]        th_eff;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign wr_ok    = push && !full && !flush;
  assign rd_ok    = pop && !empty && !flush;
  assign overrun  = push && full && !flush;
  assign underrun = pop && empty && !flush;
  assign rd_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      if (wr_ok && !rd_ok)      cnt <= cnt + 1'b1;
      else if (rd_ok && !wr_ok) cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    if (empty)                  level = 3'd0;
    else if (cnt < CW'(Q))      level = 3'd1;
    else if (cnt < CW'(2 * Q))  level = 3'd2;
    else if (cnt < CW'(3 * Q))  level = 3'd3;
    else if (!full)             level = 3'd4;
    else                        level = 3'd5;
  end

  assign th_eff = (thresh > 3'd4) ? 3'd4 : thresh;
  assign req    = rx_mode ? (level > th_eff) : (level <= th_eff);
  assign irq    = req && irq_en;

  assert_level_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= 3'd5);

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !pop) |=> (level == 3'd5));

  assert_empty_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !push) |=> (level == 3'd0));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == 3'd0));

  assert_rx_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode && level == 3'd0) |-> !req);

  assert_tx_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_mode && level == 3'd5) |-> !req);

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && req));
endmodule

// File: tb/audio_fifo_req_tb.sv
module audio_fifo_req_tb;
  logic        clk = 0, rst_n = 0;
  logic        flush = 0, rx_mode = 0, irq_en = 0, push = 0, pop = 0;
  logic [2:0]  thresh = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [2:0]  level;
  logic        req, irq, overrun, underrun;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] mq[$];

  always #10 clk = ~clk;

  audio_fifo_req u_dut (.clk(clk), .rst_n(rst_n), .flush(flush), .rx_mode(rx_mode),
    .thresh(thresh), .irq_en(irq_en), .push(push), .wr_data(wr_data), .pop(pop),
    .rd_data(rd_data), .level(level), .req(req), .irq(irq), .overrun(overrun),
    .underrun(underrun));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [2:0] lvl_of(input int n);
    if (n == 0) return 3'd0;
    if (n < 2)  return 3'd1;
    if (n < 4)  return 3'd2;
    if (n < 6)  return 3'd3;
    if (n < 8)  return 3'd4;
    return 3'd5;
  endfunction

  // one clock of stimulus: drive at negedge, check combinational flags, then commit
  task automatic cyc(input logic p, input logic [31:0] d, input logic o, input logic f);
    int c;
    push = p; wr_data = d; pop = o; flush = f;
    #2;
    c = mq.size();
    chk("R7 overrun", 32'(overrun), 32'(p && !f && c == 8));
    chk("R8 underrun", 32'(underrun), 32'(o && !f && c == 0));
    if (o && !f && c > 0) chk("R1 rd_data", rd_data, mq[0]);
    @(posedge clk);
    if (f) mq.delete();
    else begin
      if (o && c > 0) void'(mq.pop_front());
      if (p && c < 8) mq.push_back(d);
    end
    @(negedge clk);
    push = 0; pop = 0; flush = 0;
  endtask

  task automatic sweep();
    int n;
    logic [2:0] t, l;
    logic e;
    n = mq.size();
    l = lvl_of(n);
    chk("R2 level", 32'(level), 32'(l));
    for (int dr = 0; dr < 2; dr++)
      for (int th = 0; th < 8; th++)
        for (int en = 0; en < 2; en++) begin
          rx_mode = dr[0]; thresh = th[2:0]; irq_en = en[0];
          #1;
          t = (th > 4) ? 3'd4 : th[2:0];
          e = dr[0] ? (l > t) : (l <= t);
          chk(dr[0] ? (th > 4 ? "R4 R5 rx req" : "R4 rx req")
                    : (th > 4 ? "R3 R5 tx req" : "R3 tx req"), 32'(req), 32'(e));
          chk("R6 irq", 32'(irq), 32'(e && en[0]));
        end
    rx_mode = 0; thresh = 0; irq_en = 0;
  endtask

  initial begin
    #100000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset level", 32'(level), 0);
    chk("R10 reset overrun", 32'(overrun), 0);
    chk("R10 reset underrun", 32'(underrun), 0);

    // R8: underrun on empty, then empty pop with push stores the push
    cyc(0, 0, 1, 0);
    chk("R8 level after underrun", 32'(level), 0);
    cyc(1, 32'hA5A5_0001, 1, 0);
    chk("R8 push kept", 32'(level), 1);
    cyc(0, 0, 1, 0);

    // fill 0..8 with full configuration sweep at each count
    sweep();
    for (int i = 0; i < 8; i++) begin
      cyc(1, 32'h1000_0000 + 32'(i * 7), 0, 0);
      sweep();
    end

    // R7: push while full, with and without pop
    cyc(1, 32'hDEAD_BEEF, 0, 0);
    chk("R7 still full", 32'(level), 5);
    cyc(1, 32'hBAD0_0001, 1, 0);
    chk("R7 one popped", 32'(level), 4);

    // drain and check order
    while (mq.size() > 0) cyc(0, 0, 1, 0);
    chk("R1 drained", 32'(level), 0);

    // R11: simultaneous push/pop mid-fill
    for (int i = 0; i < 3; i++) cyc(1, 32'h2000_0000 + 32'(i), 0, 0);
    for (int i = 0; i < 6; i++) begin
      cyc(1, 32'h3000_0000 + 32'(i), 1, 0);
      chk("R11 count kept", 32'(level), 32'(lvl_of(3)));
    end
    while (mq.size() > 0) cyc(0, 0, 1, 0);

    // R9: flush with push and pop
    for (int i = 0; i < 5; i++) cyc(1, 32'h4000_0000 + 32'(i), 0, 0);
    cyc(1, 32'h5555_5555, 1, 1);
    chk("R9 flushed", 32'(level), 0);
    for (int i = 0; i < 8; i++) cyc(1, 32'h6000_0000 + 32'(i), 0, 0);
    cyc(1, 32'h7777_7777, 0, 1);
    chk("R9 flushed from full", 32'(level), 0);
    cyc(0, 0, 1, 1);
    chk("R9 flush when empty", 32'(level), 0);
    cyc(1, 32'h8000_0001, 0, 0);
    cyc(0, 0, 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule